// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block is the hardware half of a receive descriptor ring kept in system memory. Software fills descriptors with a buffer address and a control word that marks the slot as owned by the engine. It then moves a tail index forward to post them. When a frame is announced on the frame stream, the engine looks at the descriptor under its current index. It reads the control word, checks ownership and fetches the buffer address. It hands that address and the frame's stored length to a buffer writer downstream, then overwrites the control word with a status word. That write returns the slot to software, after which the index advances and wraps at the end of the ring.

The engine never fills the descriptor that the tail index points at. A fully posted ring therefore always keeps one slot back. Frames that find no usable slot are dropped and counted. A descriptor that asks for it raises a sticky receive interrupt, which software clears with a one-cycle pulse. The frame byte datapath, address filtering and FIFOs lie outside the block.

All three data interfaces use valid/ready handshakes. The frame stream and the buffer stream hold their payload stable while valid is high and ready is low. A transfer completes on a clock edge where both are high. The engine raises `frame_ready` only once it has fully handled a frame. A stalled `wbuf_ready` therefore stalls the frame stream. Descriptor memory requests follow the same rule. Read data returns on `desc_rsp_valid` any number of cycles after the request is accepted, and the engine always waits for it.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset, `frame_ready`, `desc_req_valid`, `wbuf_valid` and `irq` are low and `miss_count` is zero.
- R2: The descriptor at index i, word w, sits at byte address `cfg_base + 16*i + 4*w`. The first access for each frame is a read of word 3 of the current descriptor.
- R3: If the word 3 that was read has bit 31 (owned) and bit 24 (buffer valid) set, the engine reads word 0. It then offers that value on `wbuf_addr` with the stored length on `wbuf_len`, and holds both stable until `wbuf_ready`.
- R4: Write-back stores to word 3 the stored length in bits [14:0], the error summary in bit 15, last-segment in bit 28 and first-segment in bit 29. All other bits are zero, including bit 31 (owned) and bit 30 (context).
- R5: A frame longer than `cfg_buf_size` is stored with its length cut to `cfg_buf_size`. The error summary is set, and last-segment stays set.
- R6: A frame presented with `frame_err` high is written back with the error summary set and its full (or cut) length.
- R7: An owned descriptor with bit 24 clear is written back with the error summary set and length 0. No buffer address is offered.
- R8: When the current index equals `cfg_tail`, a frame is accepted and dropped without any descriptor access, and `miss_count` increases by one.
- R9: When word 3 of the current descriptor has bit 31 clear, the frame is dropped and `miss_count` increases. Nothing is written, and the current index does not move.
- R10: After each completed descriptor the index moves to the next one, and from index `cfg_ring_last` it wraps to 0.
- R11: Completing a descriptor whose word 3 had bit 30 (interrupt on completion) set raises `irq` at the edge that accepts the frame. A completed descriptor without that bit leaves `irq` unchanged. A pulse on `irq_clr` lowers `irq`.
- R12: While `cfg_run` is low the engine issues no descriptor requests, keeps `frame_ready` low, and holds its index at 0.
- R13: `miss_count` saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Engine enable; low parks the index at 0 |
| cfg_base | input | ADDR_W | Byte address of descriptor 0 |
| cfg_ring_last | input | IDX_W | Number of descriptors minus one |
| cfg_tail | input | IDX_W | Tail index; the engine stops in front of it |
| cfg_buf_size | input | BSZ_W | Receive buffer size in bytes |
| frame_valid | input | 1 | Frame announcement valid |
| frame_ready | output | 1 | Frame fully handled (stored or dropped) |
| frame_len | input | LEN_W | Frame byte count |
| frame_err | input | 1 | Frame arrived with an error |
| desc_req_valid | output | 1 | Descriptor memory request valid |
| desc_req_ready | input | 1 | Descriptor memory request accepted |
| desc_req_write | output | 1 | High for write, low for read |
| desc_req_addr | output | ADDR_W | Request byte address |
| desc_req_wdata | output | 32 | Write data |
| desc_rsp_valid | input | 1 | Read data valid |
| desc_rsp_data | input | 32 | Read data |
| wbuf_valid | output | 1 | Buffer assignment valid |
| wbuf_ready | input | 1 | Buffer writer accepts the assignment |
| wbuf_addr | output | ADDR_W | Buffer address taken from word 0 |
| wbuf_len | output | 15 | Bytes to store into the buffer |
| irq | output | 1 | Sticky receive interrupt |
| irq_clr | input | 1 | Pulse that clears `irq` |
| miss_count | output | MISS_W | Saturating count of dropped frames |

## Verification
The bench sweeps frame lengths on both sides of the buffer size, with and without the error flag, across several laps of a four-slot ring. It computes each status word arithmetically. A design that compared lengths with the wrong inequality, or that left owned or context set, would leave a mismatching word at the computed address. A design that ignored the tail would write into the withheld slot instead of counting a miss. A design that advanced past an unowned slot would place the next frame one index too far on. Randomly stalled memory and buffer handshakes catch a design that lets a payload change before acceptance or that loses a read response. Repeated drops push the miss counter past its ceiling to expose a counter that wraps.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int OWN_BIT   = 31;
  localparam int IOC_BIT   = 30;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 28;
  localparam int BVAL_BIT  = 24;
  localparam int ERR_BIT   = 15;
  localparam int PLEN_W    = 15;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD3,
    ST_WAIT3,
    ST_RD0,
    ST_WAIT0,
    ST_BUF,
    ST_WB,
    ST_DONE,
    ST_DROP
  } eng_state_t;

  function automatic logic [31:0] pack_status(input logic [PLEN_W-1:0] len,
                                              input logic err);
    logic [31:0] w;
    w                 = '0;
    w[PLEN_W-1:0]     = len;
    w[ERR_BIT]        = err;
    w[LAST_BIT]       = 1'b1;
    w[FIRST_BIT]      = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IDX_W-1:0] ring_last,
  input  logic [IDX_W-1:0] tail,
  input  logic             advance,
  output logic [IDX_W-1:0] cur,
  output logic             at_tail
);

  logic [IDX_W-1:0] nxt;

  always_comb begin
    if (cur == ring_last) nxt = '0;
    else                  nxt = cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= '0;
    else if (!run)    cur <= '0;
    else if (advance) cur <= nxt;
  end

  assign at_tail = (cur == tail);

endmodule

// File: rtl/rxd_status_gen.sv
module rxd_status_gen
  import rxd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BSZ_W = 14
) (
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_err,
  input  logic [BSZ_W-1:0]  buf_size,
  input  logic              buf_valid,
  output logic [PLEN_W-1:0] store_len,
  output logic [31:0]       status_word
);

  logic             too_long;
  logic [LEN_W-1:0] size_ext;
  logic             err_sum;

  assign size_ext = LEN_W'(buf_size);
  assign too_long = frame_len > size_ext;

  always_comb begin
    if (!buf_valid)    store_len = '0;
    else if (too_long) store_len = PLEN_W'(buf_size);
    else               store_len = PLEN_W'(frame_len);
  end

  assign err_sum     = frame_err | too_long | ~buf_valid;
  assign status_word = pack_status(store_len, err_sum);

endmodule

// File: rtl/rxd_event_regs.sv
module rxd_event_regs #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_inc,
  input  logic              irq_set,
  input  logic              irq_clr,
  output logic              irq,
  output logic [MISS_W-1:0] miss_count
);

  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 miss_count <= '0;
    else if (miss_inc && miss_count != MISS_MAX) miss_count <= miss_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int LEN_W  = 16,
  parameter int BSZ_W  = 14,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_run,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_ring_last,
  input  logic [IDX_W-1:0]  cfg_tail,
  input  logic [BSZ_W-1:0]  cfg_buf_size,
  input  logic              frame_valid,
  output logic              frame_ready,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_err,
  output logic              desc_req_valid,
  input  logic              desc_req_ready,
  output logic              desc_req_write,
  output logic [ADDR_W-1:0] desc_req_addr,
  output logic [31:0]       desc_req_wdata,
  input  logic              desc_rsp_valid,
  input  logic [31:0]       desc_rsp_data,
  output logic              wbuf_valid,
  input  logic              wbuf_ready,
  output logic [ADDR_W-1:0] wbuf_addr,
  output logic [14:0]       wbuf_len,
  output logic              irq,
  input  logic              irq_clr,
  output logic [MISS_W-1:0] miss_count
);

  localparam int DESC_SHIFT = 4;
  localparam int WORD_SHIFT = 2;

  eng_state_t        state_q, state_d;
  logic [IDX_W-1:0]  cur_idx;
  logic              at_tail;
  logic              advance;
  logic [LEN_W-1:0]  len_q;
  logic              err_q;
  logic              ioc_q;
  logic              bval_q;
  logic [31:0]       word0_q;
  logic [PLEN_W-1:0] store_len;
  logic [31:0]       status_word;
  logic [1:0]        word_sel;
  logic [ADDR_W-1:0] desc_off;
  logic [ADDR_W-1:0] word_off;

  rxd_ring_ptr #(.IDX_W(IDX_W)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_run),
    .ring_last (cfg_ring_last),
    .tail      (cfg_tail),
    .advance   (advance),
    .cur       (cur_idx),
    .at_tail   (at_tail)
  );

  rxd_status_gen #(.LEN_W(LEN_W), .BSZ_W(BSZ_W)) stat_i (
    .frame_len   (len_q),
    .frame_err   (err_q),
    .buf_size    (cfg_buf_size),
    .buf_valid   (bval_q),
    .store_len   (store_len),
    .status_word (status_word)
  );

  rxd_event_regs #(.MISS_W(MISS_W)) evt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_inc   (state_q == ST_DROP),
    .irq_set    ((state_q == ST_DONE) && ioc_q),
    .irq_clr    (irq_clr),
    .irq        (irq),
    .miss_count (miss_count)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_run && frame_valid) state_d = at_tail ? ST_DROP : ST_RD3;
      end
      ST_RD3:   if (desc_req_ready) state_d = ST_WAIT3;
      ST_WAIT3: begin
        if (desc_rsp_valid) begin
          if (!desc_rsp_data[OWN_BIT])       state_d = ST_DROP;
          else if (desc_rsp_data[BVAL_BIT])  state_d = ST_RD0;
          else                               state_d = ST_WB;
        end
      end
      ST_RD0:   if (desc_req_ready) state_d = ST_WAIT0;
      ST_WAIT0: if (desc_rsp_valid) state_d = ST_BUF;
      ST_BUF:   if (wbuf_ready)     state_d = ST_WB;
      ST_WB:    if (desc_req_ready) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_DROP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // frame capture at start of handling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      err_q <= 1'b0;
    end else if (state_q == ST_IDLE && cfg_run && frame_valid) begin
      len_q <= frame_len;
      err_q <= frame_err;
    end
  end

  // control word flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioc_q  <= 1'b0;
      bval_q <= 1'b0;
    end else if (state_q == ST_WAIT3 && desc_rsp_valid) begin
      ioc_q  <= desc_rsp_data[IOC_BIT];
      bval_q <= desc_rsp_data[BVAL_BIT];
    end
  end

  // buffer address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  word0_q <= '0;
    else if (state_q == ST_WAIT0 && desc_rsp_valid) word0_q <= desc_rsp_data;
  end

  // descriptor request
  assign word_sel = (state_q == ST_RD0) ? 2'd0 : 2'd3;
  assign desc_off = ADDR_W'(cur_idx) << DESC_SHIFT;
  assign word_off = ADDR_W'(word_sel) << WORD_SHIFT;

  assign desc_req_valid = (state_q == ST_RD3) || (state_q == ST_RD0) || (state_q == ST_WB);
  assign desc_req_write = (state_q == ST_WB);
  assign desc_req_addr  = cfg_base + desc_off + word_off;
  assign desc_req_wdata = (state_q == ST_WB) ? status_word : 32'h0;

  // buffer stream
  assign wbuf_valid = (state_q == ST_BUF);
  assign wbuf_addr  = word0_q[ADDR_W-1:0];
  assign wbuf_len   = store_len;

  // frame stream and ring advance
  assign frame_ready = (state_q == ST_DONE) || (state_q == ST_DROP);
  assign advance     = (state_q == ST_DONE);

endmodule

// File: rtl/rxd_ring_engine_chk.sv
module rxd_ring_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int BSZ_W  = 14,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BSZ_W-1:0]  cfg_buf_size,
  input logic              frame_valid,
  input logic              frame_ready,
  input logic              desc_req_valid,
  input logic              desc_req_ready,
  input logic              desc_req_write,
  input logic [ADDR_W-1:0] desc_req_addr,
  input logic [31:0]       desc_req_wdata,
  input logic              wbuf_valid,
  input logic              wbuf_ready,
  input logic [ADDR_W-1:0] wbuf_addr,
  input logic [14:0]       wbuf_len,
  input logic              irq,
  input logic [MISS_W-1:0] miss_count
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid && !desc_req_ready |=>
      desc_req_valid && $stable(desc_req_addr) && $stable(desc_req_write));

  p_wbuf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_valid && !wbuf_ready |=>
      wbuf_valid && $stable(wbuf_addr) && $stable(wbuf_len));

  p_wb_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid && desc_req_write |->
      desc_req_wdata[31:30] == 2'b00 && desc_req_wdata[29] && desc_req_wdata[28]
      && desc_req_wdata[27:16] == 12'h000);

  p_wb_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid && desc_req_write |->
      {1'b0, desc_req_wdata[14:0]} <= 16'(cfg_buf_size));

  p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> frame_valid);

  p_irq_from_completion_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_ready && frame_valid));

  p_miss_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1);

endmodule

bind rxd_ring_engine rxd_ring_engine_chk #(
  .ADDR_W(ADDR_W), .BSZ_W(BSZ_W), .MISS_W(MISS_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_buf_size   (cfg_buf_size),
  .frame_valid    (frame_valid),
  .frame_ready    (frame_ready),
  .desc_req_valid (desc_req_valid),
  .desc_req_ready (desc_req_ready),
  .desc_req_write (desc_req_write),
  .desc_req_addr  (desc_req_addr),
  .desc_req_wdata (desc_req_wdata),
  .wbuf_valid     (wbuf_valid),
  .wbuf_ready     (wbuf_ready),
  .wbuf_addr      (wbuf_addr),
  .wbuf_len       (wbuf_len),
  .irq            (irq),
  .miss_count     (miss_count)
);

// File: tb/rxd_ring_engine_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_engine_tb_top;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;
  localparam int LEN_W  = 16;
  localparam int BSZ_W  = 14;
  localparam int MISS_W = 3;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam int BSZ = 100;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic              cfg_run = 0;
  logic [IDX_W-1:0]  cfg_tail = 0;
  logic              frame_valid = 0;
  logic [LEN_W-1:0]  frame_len = 0;
  logic              frame_err = 0;
  logic              irq_clr = 0;
  logic              frame_ready, desc_req_valid, desc_req_write, wbuf_valid, irq;
  logic              desc_req_ready, desc_rsp_valid, wbuf_ready;
  logic [ADDR_W-1:0] desc_req_addr, wbuf_addr;
  logic [31:0]       desc_req_wdata, desc_rsp_data;
  logic [14:0]       wbuf_len;
  logic [MISS_W-1:0] miss_count;

  rxd_ring_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W),
                    .BSZ_W(BSZ_W), .MISS_W(MISS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_base(BASE),
    .cfg_ring_last(3'd3), .cfg_tail(cfg_tail), .cfg_buf_size(14'(BSZ)),
    .frame_valid(frame_valid), .frame_ready(frame_ready), .frame_len(frame_len),
    .frame_err(frame_err), .desc_req_valid(desc_req_valid), .desc_req_ready(desc_req_ready),
    .desc_req_write(desc_req_write), .desc_req_addr(desc_req_addr),
    .desc_req_wdata(desc_req_wdata), .desc_rsp_valid(desc_rsp_valid),
    .desc_rsp_data(desc_rsp_data), .wbuf_valid(wbuf_valid), .wbuf_ready(wbuf_ready),
    .wbuf_addr(wbuf_addr), .wbuf_len(wbuf_len), .irq(irq), .irq_clr(irq_clr),
    .miss_count(miss_count));

  // memory model with a host write port
  logic [31:0] mem [0:127];
  logic        h_we = 0;
  logic [6:0]  h_idx = 0;
  logic [31:0] h_data = 0;
  logic [7:0]  cyc = 0;
  int          req_cnt = 0, wr_cnt = 0, wbuf_cnt = 0;
  logic [31:0] last_wr_addr = 0, last_buf_addr = 0;
  logic [14:0] last_buf_len = 0;
  logic        ready_seen = 0;

  assign desc_req_ready = (cyc[1:0] != 2'd0);
  assign wbuf_ready     = cyc[1];

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    desc_rsp_valid <= 1'b0;
    if (h_we) mem[h_idx] <= h_data;
    if (desc_req_valid && desc_req_ready) begin
      req_cnt <= req_cnt + 1;
      if (desc_req_write) begin
        mem[desc_req_addr[8:2]] <= desc_req_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= desc_req_addr;
      end else begin
        desc_rsp_data  <= mem[desc_req_addr[8:2]];
        desc_rsp_valid <= 1'b1;
      end
    end
    if (wbuf_valid && wbuf_ready) begin
      wbuf_cnt <= wbuf_cnt + 1;
      last_buf_addr <= wbuf_addr;
      last_buf_len  <= wbuf_len;
    end
    if (frame_ready) ready_seen <= 1'b1;
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int idx, input logic [31:0] d);
    @(negedge clk); h_we = 1; h_idx = 7'(idx); h_data = d;
    @(negedge clk); h_we = 0;
  endtask

  task automatic post(input int slot, input logic [31:0] addr, input bit own,
                      input bit ioc, input bit bv);
    host_wr(64 + slot*4 + 0, addr);
    host_wr(64 + slot*4 + 3, {own, ioc, 5'b0, bv, 24'h0});
  endtask

  task automatic wait_accept();
    while (1) begin
      @(negedge clk);
      if (frame_ready) begin
        @(negedge clk);
        frame_valid = 0;
        break;
      end
    end
  endtask

  task automatic send(input int len, input bit err);
    @(negedge clk);
    frame_len = 16'(len); frame_err = err; frame_valid = 1;
    wait_accept();
  endtask

  function automatic logic [31:0] exp_w3(input int len, input bit err, input bit bv);
    int l; bit es;
    l  = !bv ? 0 : (len > BSZ ? BSZ : len);
    es = err || (len > BSZ) || !bv;
    return {4'b0011, 12'h000, es, 15'(l)};
  endfunction

  function automatic int exp_len(input int len);
    return len > BSZ ? BSZ : len;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int idx;
    int lens [7] = '{0, 1, 99, 100, 101, 500, 40000};
    int n;
    int rc, wc, bc;
    logic [2:0] m;
    idx = 0; n = 0;
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!frame_ready && !desc_req_valid && !wbuf_valid, "R1 handshakes idle",
          {29'd0, frame_ready, desc_req_valid, wbuf_valid}, 0);
    check(!irq && miss_count == 0, "R1 irq/miss", {28'd0, irq, miss_count}, 0);
    rst_n = 1;

    // R12: stopped engine holds the frame
    post(0, 32'h8000_0000, 1, 1, 1);
    cfg_tail = 3'd1;
    @(negedge clk);
    frame_len = 16'd50; frame_err = 0; frame_valid = 1;
    repeat (20) @(negedge clk);
    check(!ready_seen, "R12 no accept while stopped", {31'd0, ready_seen}, 0);
    check(req_cnt == 0, "R12 no requests while stopped", req_cnt, 0);
    cfg_run = 1;
    wait_accept();
    check(mem[64+3] == exp_w3(50, 0, 1), "R4 first frame status", mem[67], exp_w3(50, 0, 1));
    check(last_buf_addr == 32'h8000_0000 && last_buf_len == 15'd50, "R3 buffer offer",
          last_buf_addr, 32'h8000_0000);
    check(irq, "R11 irq raised", {31'd0, irq}, 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    check(!irq, "R11 irq cleared", {31'd0, irq}, 0);
    idx = 1;

    // length / error sweep across ring laps
    for (int e = 0; e < 2; e++) begin
      for (int k = 0; k < 7; k++) begin
        logic [31:0] ba;
        bit ioc;
        ba  = 32'h9000_0000 + 32'(n) * 32'h1000;
        ioc = n[0];
        post(idx, ba, 1, ioc, 1);
        cfg_tail = 3'((idx + 1) % 4);
        bc = wbuf_cnt;
        send(lens[k], e[0]);
        check(mem[64 + idx*4 + 3] == exp_w3(lens[k], e[0], 1),
              (lens[k] > BSZ) ? "R5 truncated status" : (e ? "R6 error status" : "R4 status"),
              mem[64 + idx*4 + 3], exp_w3(lens[k], e[0], 1));
        check(last_wr_addr == BASE + 32'(idx*16 + 12), "R2 R10 write-back address",
              last_wr_addr, BASE + 32'(idx*16 + 12));
        check(wbuf_cnt == bc + 1 && last_buf_addr == ba &&
              last_buf_len == 15'(exp_len(lens[k])), "R3 buffer addr/len",
              {17'd0, last_buf_len}, 32'(exp_len(lens[k])));
        check(irq == ioc, "R11 irq follows completion flag", {31'd0, irq}, {31'd0, ioc});
        if (irq) begin
          @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        end
        idx = (idx + 1) % 4;
        n++;
      end
    end

    // R7 buffer-valid clear
    post(idx, 32'hA000_0000, 1, 0, 0);
    cfg_tail = 3'((idx + 1) % 4);
    bc = wbuf_cnt;
    send(60, 0);
    check(mem[64 + idx*4 + 3] == exp_w3(60, 0, 0), "R7 status without buffer",
          mem[64 + idx*4 + 3], exp_w3(60, 0, 0));
    check(wbuf_cnt == bc, "R7 no buffer offered", wbuf_cnt, bc);
    idx = (idx + 1) % 4;

    // R8 stop at tail
    post(idx, 32'hB000_0000, 1, 0, 1);
    cfg_tail = 3'(idx);
    rc = req_cnt;
    m  = miss_count;
    send(40, 0);
    check(req_cnt == rc, "R8 no access at tail", req_cnt, rc);
    check(miss_count == m + 3'd1, "R8 miss counted", {29'd0, miss_count}, {29'd0, m + 3'd1});
    check(mem[64 + idx*4 + 3][31], "R8 tail slot untouched", mem[64 + idx*4 + 3], 32'h8100_0000);

    // R9 unowned descriptor
    post(idx, 32'hB000_0000, 0, 0, 1);
    cfg_tail = 3'((idx + 1) % 4);
    wc = wr_cnt;
    m  = miss_count;
    send(40, 0);
    check(wr_cnt == wc, "R9 nothing written", wr_cnt, wc);
    check(miss_count == m + 3'd1, "R9 miss counted", {29'd0, miss_count}, {29'd0, m + 3'd1});
    post(idx, 32'hC000_0000, 1, 0, 1);
    send(70, 0);
    check(mem[64 + idx*4 + 3] == exp_w3(70, 0, 1), "R9 index held after drop",
          mem[64 + idx*4 + 3], exp_w3(70, 0, 1));
    check(last_buf_addr == 32'hC000_0000, "R9 buffer after drop", last_buf_addr, 32'hC000_0000);
    idx = (idx + 1) % 4;

    // R13 saturation
    cfg_tail = 3'(idx);
    for (int d = 0; d < 8; d++) send(10, 0);
    check(miss_count == 3'd7, "R13 miss saturates", {29'd0, miss_count}, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule